// File: doc/BRIEF.md
# Data TLB Miss Trap Unit

This unit watches every data memory access of a processor pipeline and compares the page number of the access against a small, fully associative set of translation entries. When a read or a write finds no usable entry, the unit carries out the processor's exception entry in hardware. It selects the handler address from the vector base, forces the status register into exception mode and saves the return state. It also records the faulting address and page number in the TLB exception registers. A write whose address does not suit its access size raises a separate alignment trap, and that trap takes priority over a miss.

All results are registered and appear one clock after the access request. The unit takes at most one trap per access. A synchronous entry write port loads the page number and valid flag of any entry. Reset clears all valid flags, so every access misses until entries are loaded. Translation to a physical address, permission checks and refill are handled elsewhere.

Top module: `dtlb_miss_trap`

## Requirements
- R1: A write on the entry port (ent_we_i) stores ent_vpn_i and ent_valid_i into entry ent_idx_i and takes effect from the next cycle. Reset clears every valid flag, so every access misses after reset.
- R2: A read (acc_write_i=0) whose page number acc_addr_i[31:12] matches no entry with its valid flag set produces, one cycle later, trap_o=1, trap_cause_o=1 and pc_o=evba_i+0x60.
- R3: A write (acc_write_i=1) under the same miss condition produces, one cycle later, trap_o=1, trap_cause_o=2 and pc_o=evba_i+0x70.
- R4: An access whose page matches a valid entry raises no trap. An entry whose page number matches but whose valid flag is clear does not count as a hit.
- R5: The access size is coded in acc_size_i as 0 for byte, 1 for halfword, and 2 or 3 for word. A halfword write with address bit 0 set, or a word write with address bits 1:0 not zero, produces trap_cause_o=3 and pc_o=evba_i+0x38 one cycle later. Byte writes and all reads are never misaligned.
- R6: A misaligned write to a page that also misses reports cause 3 only. trap_o is high for exactly one cycle for each request that traps and is low otherwise.
- R7: On every trap, rsr_o takes the sr_i value and rar_o takes the pc_i value of the request.
- R8: On every trap, sr_o equals sr_i with these changes: bits 15 (R) and 28 (J) cleared, bits 24:22 (mode) set to 110, and bits 21 (EM) and 16 (GM) set.
- R9: On a miss (cause 1 or 2), tlbear_o takes the full access address. tlbehi_o takes the page number in bits 31:12, with bit 0 (I) cleared and all other bits zero. An alignment trap leaves tlbear_o and tlbehi_o unchanged.
- R10: After reset, trap_o=0, trap_cause_o=0, and pc_o, sr_o, rsr_o, rar_o and tlbear_o are zero, while tlbehi_o is 0x00000001. Without a trap, all registered outputs except trap_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ent_we_i | input | 1 | Entry write strobe |
| ent_idx_i | input | 3 | Entry index to write |
| ent_vpn_i | input | 20 | Page number to store |
| ent_valid_i | input | 1 | Valid flag to store |
| acc_req_i | input | 1 | Data access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_addr_i | input | 32 | Virtual data address |
| sr_i | input | 32 | Current status register |
| pc_i | input | 32 | PC of the accessing instruction |
| evba_i | input | 32 | Exception vector base |
| trap_o | output | 1 | One-cycle trap pulse |
| trap_cause_o | output | 2 | 1 read miss, 2 write miss, 3 misaligned write |
| pc_o | output | 32 | Handler address |
| sr_o | output | 32 | Status register on exception entry |
| rsr_o | output | 32 | Saved return status |
| rar_o | output | 32 | Saved return address |
| tlbear_o | output | 32 | Faulting virtual address |
| tlbehi_o | output | 32 | Entry-high: faulting page and I flag |

## Verification
The hardest case to reach is an entry whose page number matches the access but whose valid flag is clear. Random addresses almost never hit a loaded page number, and this case needs that page stored with its flag off. The bench loads such an entry on purpose and draws half of its random addresses from pages already in its own copy of the table. Misaligned writes to unmapped pages are forced the same way, so the alignment priority is exercised against a real miss.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int SR_R_BIT  = 15;
  localparam int SR_GM_BIT = 16;
  localparam int SR_EM_BIT = 21;
  localparam int SR_M_LO   = 22;
  localparam int SR_M_HI   = 24;
  localparam int SR_J_BIT  = 28;
  localparam logic [2:0] SR_MODE_EXC = 3'b110;
  localparam int EHI_I_BIT = 0;

  localparam logic [31:0] VEC_ALIGN = 32'h38;
  localparam logic [31:0] VEC_RMISS = 32'h60;
  localparam logic [31:0] VEC_WMISS = 32'h70;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_RMISS = 2'd1,
    CAUSE_WMISS = 2'd2,
    CAUSE_ALIGN = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } size_e;
endpackage

// File: rtl/dtlb_table.sv
module dtlb_table #(
  parameter int NUM_ENT = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [VPN_W-1:0] wvpn_i,
  input  logic             wvalid_i,
  input  logic [VPN_W-1:0] lvpn_i,
  output logic             hit_o
);
  logic [NUM_ENT-1:0]            val_q;
  logic [NUM_ENT-1:0][VPN_W-1:0] vpn_q;
  logic [NUM_ENT-1:0]            match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      vpn_q <= '0;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (we_i && widx_i == IDX_W'(i)) begin
          val_q[i] <= wvalid_i;
          vpn_q[i] <= wvpn_i;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign match[g] = val_q[g] && (vpn_q[g] == lvpn_i);
  end

  assign hit_o = |match;

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (val_q[$past(widx_i)] == $past(wvalid_i)) && (vpn_q[$past(widx_i)] == $past(wvpn_i)));
endmodule

// File: rtl/dtlb_fault_detect.sv
module dtlb_fault_detect
  import dtlb_pkg::*;
(
  input  logic       req_i,
  input  logic       write_i,
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  input  logic       hit_i,
  output cause_e     cause_o
);
  logic misal;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE:         misal = 1'b0;
      SZ_HALF:         misal = addr_lo_i[0];
      SZ_WORD, SZ_WRD2: misal = |addr_lo_i;
      default:         misal = 1'b0;
    endcase
  end

  always_comb begin
    cause_o = CAUSE_NONE;
    if (req_i) begin
      if (write_i && misal)  cause_o = CAUSE_ALIGN;
      else if (!hit_i)       cause_o = write_i ? CAUSE_WMISS : CAUSE_RMISS;
    end
  end
endmodule

// File: rtl/dtlb_trap_regs.sv
module dtlb_trap_regs
  import dtlb_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PG_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cause_e          cause_i,
  input  logic [VA_W-1:0] addr_i,
  input  logic [31:0]     sr_i,
  input  logic [31:0]     pc_i,
  input  logic [31:0]     evba_i,
  output logic            trap_o,
  output logic [1:0]      cause_o,
  output logic [31:0]     pc_o,
  output logic [31:0]     sr_o,
  output logic [31:0]     rsr_o,
  output logic [31:0]     rar_o,
  output logic [VA_W-1:0] tlbear_o,
  output logic [31:0]     tlbehi_o
);
  localparam logic [31:0] EHI_RST = 32'(1) << EHI_I_BIT;

  logic        take, is_miss;
  logic [31:0] vec_off, sr_new, ehi_new;

  assign take    = (cause_i != CAUSE_NONE);
  assign is_miss = (cause_i == CAUSE_RMISS) || (cause_i == CAUSE_WMISS);

  always_comb begin
    unique case (cause_i)
      CAUSE_RMISS: vec_off = VEC_RMISS;
      CAUSE_WMISS: vec_off = VEC_WMISS;
      default:     vec_off = VEC_ALIGN;
    endcase
  end

  always_comb begin
    sr_new                    = sr_i;
    sr_new[SR_R_BIT]          = 1'b0;
    sr_new[SR_J_BIT]          = 1'b0;
    sr_new[SR_M_HI:SR_M_LO]   = SR_MODE_EXC;
    sr_new[SR_EM_BIT]         = 1'b1;
    sr_new[SR_GM_BIT]         = 1'b1;
  end

  always_comb begin
    ehi_new                = '0;
    ehi_new[31:PG_W]       = addr_i[VA_W-1:PG_W];
    ehi_new[EHI_I_BIT]     = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o   <= 1'b0;
      cause_o  <= CAUSE_NONE;
      pc_o     <= '0;
      sr_o     <= '0;
      rsr_o    <= '0;
      rar_o    <= '0;
      tlbear_o <= '0;
      tlbehi_o <= EHI_RST;
    end else begin
      trap_o <= take;
      if (take) begin
        cause_o <= cause_i;
        pc_o    <= evba_i + vec_off;
        sr_o    <= sr_new;
        rsr_o   <= sr_i;
        rar_o   <= pc_i;
      end
      if (is_miss) begin
        tlbear_o <= addr_i;
        tlbehi_o <= ehi_new;
      end
    end
  end

  a_r8_exc_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (sr_o[SR_M_HI:SR_M_LO] == SR_MODE_EXC) && sr_o[SR_EM_BIT] && sr_o[SR_GM_BIT]
               && !sr_o[SR_R_BIT] && !sr_o[SR_J_BIT]);
  a_r7_ret_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (rsr_o == $past(sr_i)) && (rar_o == $past(pc_i)));
  a_r2_rd_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i == CAUSE_RMISS |=> pc_o == $past(evba_i) + 32'h60);
  a_r3_wr_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i == CAUSE_WMISS |=> pc_o == $past(evba_i) + 32'h70);
  a_r9_align_keeps_ear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i == CAUSE_ALIGN |=> $stable(tlbear_o) && $stable(tlbehi_o));
  a_r9_miss_clears_i: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_miss |=> !tlbehi_o[EHI_I_BIT]);
endmodule

// File: rtl/dtlb_miss_trap.sv
module dtlb_miss_trap
  import dtlb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int VA_W    = 32,
  parameter int PG_W    = 12,
  localparam int VPN_W  = VA_W - PG_W,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ent_we_i,
  input  logic [IDX_W-1:0] ent_idx_i,
  input  logic [VPN_W-1:0] ent_vpn_i,
  input  logic             ent_valid_i,
  input  logic             acc_req_i,
  input  logic             acc_write_i,
  input  logic [1:0]       acc_size_i,
  input  logic [VA_W-1:0]  acc_addr_i,
  input  logic [31:0]      sr_i,
  input  logic [31:0]      pc_i,
  input  logic [31:0]      evba_i,
  output logic             trap_o,
  output logic [1:0]       trap_cause_o,
  output logic [31:0]      pc_o,
  output logic [31:0]      sr_o,
  output logic [31:0]      rsr_o,
  output logic [31:0]      rar_o,
  output logic [VA_W-1:0]  tlbear_o,
  output logic [31:0]      tlbehi_o
);
  logic   hit;
  cause_e cause;

  dtlb_table #(.NUM_ENT(NUM_ENT), .VPN_W(VPN_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ent_we_i),
    .widx_i   (ent_idx_i),
    .wvpn_i   (ent_vpn_i),
    .wvalid_i (ent_valid_i),
    .lvpn_i   (acc_addr_i[VA_W-1:PG_W]),
    .hit_o    (hit)
  );

  dtlb_fault_detect u_detect (
    .req_i     (acc_req_i),
    .write_i   (acc_write_i),
    .size_i    (acc_size_i),
    .addr_lo_i (acc_addr_i[1:0]),
    .hit_i     (hit),
    .cause_o   (cause)
  );

  dtlb_trap_regs #(.VA_W(VA_W), .PG_W(PG_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cause_i  (cause),
    .addr_i   (acc_addr_i),
    .sr_i     (sr_i),
    .pc_i     (pc_i),
    .evba_i   (evba_i),
    .trap_o   (trap_o),
    .cause_o  (trap_cause_o),
    .pc_o     (pc_o),
    .sr_o     (sr_o),
    .rsr_o    (rsr_o),
    .rar_o    (rar_o),
    .tlbear_o (tlbear_o),
    .tlbehi_o (tlbehi_o)
  );

  a_r6_align_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && acc_write_i && acc_size_i == 2'd1 && acc_addr_i[0]) |=>
      trap_o && trap_cause_o == 2'd3);
  a_r4_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && !acc_write_i && hit) |=> !trap_o);
  a_r6_no_idle_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_req_i |=> !trap_o);
endmodule

// File: tb/dtlb_miss_trap_bench.sv
module dtlb_miss_trap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ent_we = 0, ent_valid = 0, req = 0, wr = 0;
  logic [2:0]  ent_idx = 0;
  logic [19:0] ent_vpn = 0;
  logic [1:0]  sz = 0;
  logic [31:0] addr = 0, sr = 0, pc = 0, evba = 0;
  logic        trap;
  logic [1:0]  cause;
  logic [31:0] pc_o, sr_o, rsr_o, rar_o, ear_o, ehi_o;

  dtlb_miss_trap u_dtlb_miss_trap (
    .clk_i(clk), .rst_ni(rst_n), .ent_we_i(ent_we), .ent_idx_i(ent_idx),
    .ent_vpn_i(ent_vpn), .ent_valid_i(ent_valid), .acc_req_i(req),
    .acc_write_i(wr), .acc_size_i(sz), .acc_addr_i(addr), .sr_i(sr),
    .pc_i(pc), .evba_i(evba), .trap_o(trap), .trap_cause_o(cause),
    .pc_o(pc_o), .sr_o(sr_o), .rsr_o(rsr_o), .rar_o(rar_o),
    .tlbear_o(ear_o), .tlbehi_o(ehi_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [19:0] r_vpn [8];
  logic        r_val [8];
  logic [1:0]  m_cause = 0;
  logic [31:0] m_pc = 0, m_sr = 0, m_rsr = 0, m_rar = 0, m_ear = 0, m_ehi = 32'h1;

  task automatic chk(input string req_tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] f_cause(input logic w, input logic [1:0] s, input logic [31:0] a);
    logic mis, hit;
    mis = w && ((s == 2'd1 && a[0]) || (s >= 2'd2 && a[1:0] != 2'b00));
    hit = 1'b0;
    for (int i = 0; i < 8; i++) if (r_val[i] && r_vpn[i] == a[31:12]) hit = 1'b1;
    if (mis) return 2'd3;
    if (!hit) return w ? 2'd2 : 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [31:0] f_sr(input logic [31:0] s);
    logic [31:0] n;
    n = s;
    n[15] = 1'b0; n[28] = 1'b0; n[24:22] = 3'b110; n[21] = 1'b1; n[16] = 1'b1;
    return n;
  endfunction

  task automatic load(input int idx, input logic [19:0] v, input logic val);
    @(negedge clk);
    ent_we = 1; ent_idx = 3'(idx); ent_vpn = v; ent_valid = val;
    @(negedge clk);
    ent_we = 0;
    r_vpn[idx] = v; r_val[idx] = val;
  endtask

  task automatic acc(input logic w, input logic [1:0] s, input logic [31:0] a, input string tag);
    logic [1:0] c;
    @(negedge clk);
    req = 1; wr = w; sz = s; addr = a;
    sr = $urandom; pc = $urandom; evba = {$urandom, 8'h00} ;
    c = f_cause(w, s, a);
    if (c != 0) begin
      m_cause = c;
      m_pc = evba + (c == 2'd1 ? 32'h60 : c == 2'd2 ? 32'h70 : 32'h38);
      m_sr = f_sr(sr); m_rsr = sr; m_rar = pc;
      if (c != 2'd3) begin m_ear = a; m_ehi = {a[31:12], 12'h000}; end
    end
    @(negedge clk);
    req = 0;
    chk(tag, "trap", 32'(trap), 32'(c != 0));
    chk(tag, "cause", 32'(cause), 32'(m_cause));
    chk(tag, "pc", pc_o, m_pc);
    chk("R8", "sr", sr_o, m_sr);
    chk("R7", "rsr", rsr_o, m_rsr);
    chk("R7", "rar", rar_o, m_rar);
    chk("R9", "tlbear", ear_o, m_ear);
    chk("R9", "tlbehi", ehi_o, m_ehi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) begin r_vpn[i] = 0; r_val[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R10", "trap", 32'(trap), 0);
    chk("R10", "cause", 32'(cause), 0);
    chk("R10", "pc", pc_o, 0);
    chk("R10", "sr", sr_o, 0);
    chk("R10", "tlbear", ear_o, 0);
    chk("R10", "tlbehi", ehi_o, 32'h1);
    rst_n = 1;
    acc(0, 2'd2, 32'h0000_5004, "R1");        // empty after reset
    load(0, 20'h00005, 1);
    load(3, 20'hABCDE, 0);
    load(7, 20'hFFFFF, 1);
    acc(0, 2'd2, 32'h0000_5004, "R4");        // hit
    acc(0, 2'd2, 32'hABCD_E010, "R4");        // match, valid clear
    acc(1, 2'd2, 32'h0000_5008, "R4");
    acc(1, 2'd2, 32'h0009_0000, "R3");
    acc(1, 2'd1, 32'h0000_5001, "R5");
    acc(1, 2'd2, 32'h1234_5002, "R6");        // misaligned and miss
    acc(1, 2'd0, 32'h1234_5003, "R5");        // byte never misaligned
    acc(0, 2'd2, 32'hFFFF_F003, "R5");        // reads unchecked
    acc(1, 2'd3, 32'h0000_5002, "R5");
    acc(0, 2'd1, 32'h0042_0001, "R2");
    @(negedge clk);
    chk("R6", "idle trap", 32'(trap), 0);
    chk("R10", "hold pc", pc_o, m_pc);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      if ($urandom_range(0, 9) == 0)
        load($urandom_range(0, 7), 20'($urandom_range(0, 15)), 1'($urandom));
      a = $urandom;
      if ($urandom_range(0, 1) == 1) a[31:12] = r_vpn[$urandom_range(0, 7)];
      else if ($urandom_range(0, 1) == 1) a[31:12] = 20'($urandom_range(0, 15));
      acc(1'($urandom), 2'($urandom), a, "R2");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule